// File: doc/BRIEF.md
# USB Full-Speed Serial Receive Engine

This block sits between a bit-recovery front end and a byte-oriented link-layer engine. Once per recovered bit it receives a strobe and the sampled two-wire line state. While the line is idle it hunts for the start-of-packet synchronisation pattern. Once that pattern is found it raises a receive-active flag, NRZI-decodes the following symbols, drops the stuffed zeros and packs the data bits LSB first into a byte-wide holding register. A one-clock valid pulse tells the consumer that a complete byte can be latched.

A packet ends normally when the line holds SE0 for at least two bit times and then returns to J. Receive-active then falls and any unfinished byte is thrown away. If the stuffing rule is broken or the line signalling is illegal, the packet is aborted: receive-active falls and an error flag pulses in the same clock. The engine then returns to hunting for the next packet.

Top module: `usb_fs_rx_engine`

## Requirements
- R1: After reset, rx_active, rx_valid and rx_error are 0.
- R2: The line state is coded with bit 0 = D+ and bit 1 = D-: 2'b01 is J, 2'b10 is K, 2'b00 is SE0 and 2'b11 is SE1. rx_active rises only when two consecutive K symbols follow at least MIN_ALT (default 4) consecutive symbol changes between J and K. A K-K pair without that alternation does not start a packet.
- R3: Inside a packet, a symbol equal to the previous one decodes as 1 and a change decodes as 0. Data bits fill rx_data LSB first.
- R4: rx_valid is high for exactly one clock per completed byte, and rx_data holds that byte in the same clock.
- R5: After RUN_MAX (default 6) consecutive decoded 1s, counted from the first bit after the synchronisation pattern, the next decoded 0 is discarded. This rule also applies when the run crosses a byte boundary.
- R6: SE0 for at least two strobes followed by J ends the packet: rx_active falls and rx_error stays 0.
- R7: Bits of an incomplete byte left at the end of a packet produce no rx_valid.
- R8: A decoded 1 arriving after RUN_MAX consecutive 1s is a stuff error: rx_error pulses for one clock and rx_active falls in that same clock.
- R9: Inside a packet, a single SE0 followed by J or K, or any SE1, is a receive error handled as in R8.
- R10: A clock without bit_stb changes neither rx_active nor rx_data, and it never raises rx_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One-clock strobe marking a recovered bit |
| line_st | input | 2 | Sampled line state (bit 0 = D+, bit 1 = D-) |
| rx_data | output | 8 | Receive holding register |
| rx_valid | output | 1 | One-clock pulse when rx_data holds a new byte |
| rx_active | output | 1 | High from synchronisation pattern detection to packet end |
| rx_error | output | 1 | One-clock pulse on an aborted packet |

## Verification
The hardest case to reach is a stuff bit that falls right at a byte boundary, or a run of ones that breaks the stuffing rule. A correct transmitter never produces a stuff error, and whether a stuff bit lands on a boundary depends on the data. The stimulus therefore uses an encoder in the bench that stuffs zeros the way a real transmitter does, and it sends 0xFF pairs so that the stuff bits fall inside and across bytes. A second, raw path sends unstuffed bits, so seven ones in a row and a lone SE0 can be forced in the middle of a packet.

// File: rtl/usb_fs_rx_engine.sv
module usb_fs_rx_engine #(
  parameter int MIN_ALT = 4,
  parameter int RUN_MAX = 6,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic [1:0]        line_st,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_active,
  output logic              rx_error
);
  localparam int AW = $clog2(MIN_ALT + 1);
  localparam int OW = $clog2(RUN_MAX + 1);
  localparam int BW = $clog2(BYTE_W);
  localparam logic [1:0] SYM_SE0 = 2'b00;
  localparam logic [1:0] SYM_J   = 2'b01;
  localparam logic [1:0] SYM_K   = 2'b10;
  localparam logic [AW-1:0] ALT_TOP = AW'(MIN_ALT);
  localparam logic [OW-1:0] RUN_TOP = OW'(RUN_MAX);
  localparam logic [BW-1:0] BIT_TOP = BW'(BYTE_W - 1);

  typedef enum logic [0:0] {ST_HUNT, ST_DATA} st_t;

  st_t              state;
  logic [1:0]       prev_sym;
  logic [AW-1:0]    alt_cnt;
  logic [OW-1:0]    ones_cnt;
  logic [BW-1:0]    bit_cnt;
  logic [1:0]       se0_cnt;
  logic [BYTE_W-1:0] shreg;

  logic is_jk, dec_bit, sym_chg;
  assign is_jk   = (line_st == SYM_J) || (line_st == SYM_K);
  assign sym_chg = (line_st != prev_sym);
  assign dec_bit = !sym_chg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_HUNT;
      prev_sym  <= SYM_J;
      alt_cnt   <= '0;
      ones_cnt  <= '0;
      bit_cnt   <= '0;
      se0_cnt   <= '0;
      shreg     <= '0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      rx_active <= 1'b0;
      rx_error  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_error <= 1'b0;
      if (bit_stb) begin
        prev_sym <= line_st;
        if (state == ST_HUNT) begin
          if (!is_jk) begin
            alt_cnt <= '0;
          end else if (sym_chg) begin
            if (alt_cnt != ALT_TOP) alt_cnt <= alt_cnt + 1'b1;
          end else if (line_st == SYM_K && alt_cnt == ALT_TOP) begin
            state     <= ST_DATA;
            rx_active <= 1'b1;
            alt_cnt   <= '0;
            ones_cnt  <= '0;
            bit_cnt   <= '0;
            se0_cnt   <= '0;
          end else begin
            alt_cnt <= '0;
          end
        end else begin
          if (line_st == SYM_SE0) begin
            if (se0_cnt != 2'd2) se0_cnt <= se0_cnt + 1'b1;
          end else if (!is_jk) begin
            state     <= ST_HUNT;
            rx_active <= 1'b0;
            rx_error  <= 1'b1;
          end else if (se0_cnt != 2'd0) begin
            state     <= ST_HUNT;
            rx_active <= 1'b0;
            se0_cnt   <= '0;
            if (!(se0_cnt == 2'd2 && line_st == SYM_J)) rx_error <= 1'b1;
          end else if (ones_cnt == RUN_TOP) begin
            if (dec_bit) begin
              state     <= ST_HUNT;
              rx_active <= 1'b0;
              rx_error  <= 1'b1;
            end else begin
              ones_cnt <= '0;
            end
          end else begin
            ones_cnt <= dec_bit ? ones_cnt + 1'b1 : '0;
            shreg    <= {dec_bit, shreg[BYTE_W-1:1]};
            bit_cnt  <= bit_cnt + 1'b1;
            if (bit_cnt == BIT_TOP) begin
              bit_cnt  <= '0;
              rx_data  <= {dec_bit, shreg[BYTE_W-1:1]};
              rx_valid <= 1'b1;
            end
          end
        end
      end
    end
  end

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_valid_in_packet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_active);
  assert_error_ends_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_error |-> !rx_active);
  assert_error_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_error |=> !rx_error);
  assert_active_rises_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active) |-> $past(bit_stb));
  assert_idle_clock_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> ($stable(rx_active) && $stable(rx_data) && !rx_valid));
endmodule

// File: tb/usb_fs_rx_engine_tb.sv
module usb_fs_rx_engine_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_stb = 1'b0;
  logic [1:0] line_st = 2'b01;
  logic [7:0] rx_data;
  logic       rx_valid, rx_active, rx_error;

  int checks = 0;
  int failures = 0;
  int err_seen = 0;
  logic [7:0] exp_q[$];
  logic [1:0] lvl;
  int ones;

  always #2.5 clk = ~clk;

  usb_fs_rx_engine u_dut (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .line_st(line_st),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_active(rx_active), .rx_error(rx_error)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) check(0, "R7 unexpected rx_valid", rx_data, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(rx_data == e, "R3/R4 byte value", rx_data, e);
      end
    end
    if (rst_n && rx_error) err_seen++;
  end

  task automatic sym(input logic [1:0] s);
    @(negedge clk);
    line_st = s; bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_bit(input bit b, input bit stuff);
    if (!b) lvl = {lvl[0], lvl[1]};
    sym(lvl);
    if (stuff) begin
      ones = b ? ones + 1 : 0;
      if (ones == 6) begin
        lvl = {lvl[0], lvl[1]};
        sym(lvl);
        ones = 0;
      end
    end
  endtask

  task automatic send_byte(input logic [7:0] v);
    exp_q.push_back(v);
    for (int i = 0; i < 8; i++) send_bit(v[i], 1'b1);
  endtask

  task automatic send_sync();
    sym(2'b01);
    for (int i = 0; i < 3; i++) begin sym(2'b10); sym(2'b01); end
    sym(2'b10); sym(2'b10);
    lvl = 2'b10; ones = 0;
  endtask

  task automatic send_eop();
    sym(2'b00); sym(2'b00); sym(2'b01); sym(2'b01);
    lvl = 2'b01;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int e0;
    repeat (4) @(negedge clk);
    check(rx_active == 0 && rx_valid == 0 && rx_error == 0, "R1 reset outputs",
          {rx_active, rx_valid, rx_error}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10: sync symbols presented without strobes
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); line_st = (i % 2 == 0 || i == 7) ? 2'b10 : 2'b01;
    end
    @(negedge clk); line_st = 2'b01;
    check(rx_active == 0, "R10 no strobe no packet", rx_active, 0);

    // R2: K-K without alternation
    sym(2'b01); sym(2'b10); sym(2'b10); sym(2'b01);
    check(rx_active == 0, "R2 KK without alternation", rx_active, 0);

    // R2, R3, R4, R6: normal packet
    send_sync();
    check(rx_active == 1, "R2 active after sync", rx_active, 1);
    send_byte(8'hA5); send_byte(8'h3C); send_byte(8'h01);
    e0 = err_seen;
    send_eop();
    check(rx_active == 0, "R6 active falls at EOP", rx_active, 0);
    check(err_seen == e0, "R6 no error at EOP", err_seen - e0, 0);
    check(exp_q.size() == 0, "R4 all bytes delivered", exp_q.size(), 0);

    // R5: stuffing inside and across bytes
    send_sync();
    send_byte(8'hFF); send_byte(8'hFF); send_byte(8'h7E); send_byte(8'h80);
    send_eop();
    check(exp_q.size() == 0, "R5 stuffed bytes delivered", exp_q.size(), 0);
    check(err_seen == e0, "R5 no stuff error on legal stream", err_seen - e0, 0);

    // R7: partial byte dropped
    send_sync();
    send_byte(8'h5A);
    send_bit(1'b0, 1'b1); send_bit(1'b1, 1'b1); send_bit(1'b0, 1'b1);
    send_eop();
    check(exp_q.size() == 0, "R7 full byte delivered", exp_q.size(), 0);
    check(rx_active == 0, "R7 active low after EOP", rx_active, 0);

    // R8: seventh consecutive one
    send_sync();
    send_byte(8'h12);
    for (int i = 0; i < 6; i++) send_bit(1'b1, 1'b0);
    check(rx_active == 1, "R8 still active after six ones", rx_active, 1);
    e0 = err_seen;
    send_bit(1'b1, 1'b0);
    check(err_seen == e0 + 1, "R8 error pulse on seventh one", err_seen - e0, 1);
    check(rx_active == 0, "R8 active dropped", rx_active, 0);
    check(exp_q.size() == 0, "R8 byte before error delivered", exp_q.size(), 0);
    send_eop();

    // R9: single SE0 then J
    send_sync();
    send_byte(8'hC3);
    e0 = err_seen;
    sym(2'b00); sym(2'b01);
    check(err_seen == e0 + 1, "R9 error on single SE0", err_seen - e0, 1);
    check(rx_active == 0, "R9 active dropped", rx_active, 0);
    send_eop();

    // R9: SE1 inside packet
    send_sync();
    e0 = err_seen;
    sym(2'b11);
    check(err_seen == e0 + 1, "R9 error on SE1", err_seen - e0, 1);
    send_eop();

    // recovery after errors
    send_sync();
    send_byte(8'h69);
    send_eop();
    check(exp_q.size() == 0, "R3 packet after errors", exp_q.size(), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule